// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block sits between an 8-bit accumulator-style CPU's instruction decoder and its single-port byte memory. Given an opcode, it picks the operand addressing mode from the opcode's fields. It then fetches whatever operand and pointer bytes that mode needs and applies the X or Y index. It hands back the 16-bit address at which the operand lives. It reads memory only for address formation. The final data read or write is left to the caller, as are the ALU, the register file, the stack and interrupts.

A transaction begins when `start` is sampled high while the block is idle. The opcode, the write intent, the fetch pointer and both index registers are all captured on that edge. Memory reads are issued with a one-cycle latency: the byte for an address presented with `memRd` high must appear on `memRdata` in the following cycle. When the address is known, `done` pulses for one cycle. The effective address, the mode flags, the page-cross penalty flag and the count of operand bytes consumed are then valid, and they hold until the next start.

Top module: `ea_sequencer`

## Requirements
- R1: The opcode is split as bits 7:5 (op group selector), bits 4:2 (mode field) and bits 1:0 (class). For class 01 the mode field values 0 to 7 select, in order: pre-indexed indirect (zp,X), zero page, immediate, absolute, post-indexed indirect (zp),Y, zero page X, absolute Y, absolute X.
- R2: For class 00 the mode field maps 000 to immediate, 001 to zero page, 011 to absolute, 101 to zero page X and 111 to absolute X. Values 010, 100 and 110 raise `illegalFlag`. Class 11 is always illegal. An illegal opcode reads no memory, reports zero bytes and an address of 0.
- R3: For class 10, mode field 010 targets the accumulator: `accTarget` is 1, no memory is read, and the address is 0 with zero bytes used. Values 100 and 110 are illegal. When bits 7:5 are 100 or 101, the indexed forms 101 and 111 use Y instead of X.
- R4: Zero-page modes read one operand byte as the low address byte with a high byte of 0. An index is added to the low byte only, so the result wraps within page zero.
- R5: Absolute modes read two operand bytes, low then high. An index is added to the full 16-bit address.
- R6: For (zp,X), X is added to the operand byte modulo 256 before the pointer is read. The pointer is read low byte then high byte, and the high byte comes from the next page-zero location, with 0xFF wrapping to 0x00.
- R7: For (zp),Y, the pointer is read from the operand byte and the following page-zero location, and Y is added to the full 16-bit pointer.
- R8: Immediate mode sets `immFlag`, returns the fetch-pointer value as the address, counts one byte and reads no memory. An immediate mode requested with `isWrite`=1 is illegal instead.
- R9: `extraCycle` is 1 only for a read in absolute X, absolute Y or (zp),Y when adding the index carries out of the low address byte. It is 0 for all writes and all other modes.
- R10: Operand bytes are read at consecutive addresses starting at `pcIn`. `bytesUsed` reports 1 for zero-page and indirect modes and 2 for absolute modes.
- R11: `done` is a one-cycle pulse, with no read issued in that cycle. It rises 1 cycle after the start edge for immediate, accumulator and illegal cases, 3 for zero page, 4 for absolute and 5 for the indirect modes. `start` is ignored while busy.
- R12: After reset, `done`, `memRd`, all flags, `bytesUsed` and `effAddr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| opcode | input | 8 | Instruction opcode |
| isWrite | input | 1 | The operand access will be a write |
| pcIn | input | 16 | Address of the first operand byte |
| xIdx | input | 8 | X index register value |
| yIdx | input | 8 | Y index register value |
| memAddr | output | 16 | Memory read address |
| memRd | output | 1 | Memory read strobe |
| memRdata | input | 8 | Read data, one cycle after the strobe |
| done | output | 1 | Result valid pulse |
| effAddr | output | 16 | Effective operand address |
| accTarget | output | 1 | Operand is the accumulator |
| immFlag | output | 1 | Operand is the immediate byte |
| illegalFlag | output | 1 | Opcode/intent has no legal mode |
| extraCycle | output | 1 | Page-cross read penalty applies |
| bytesUsed | output | 2 | Operand bytes consumed |

## Verification
The start-to-done interval is fixed per mode: 1 cycle for immediate, accumulator and illegal cases, 3 for zero page, 4 for absolute and 5 for the two indirect forms. Each scenario counts falling edges from the start edge until `done` appears and compares that count with the mode's figure. All result ports are sampled on that falling edge. The bench also checks that `done` is low one cycle later. Its memory model answers each strobe on the next rising edge and counts the strobes, so the number of reads is checked per mode together with the address.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [3:0] {
    MD_NONE, MD_IMM, MD_ZP, MD_ZPX, MD_ZPY, MD_ABS, MD_ABSX, MD_ABSY,
    MD_INDX, MD_INDY, MD_ACC, MD_ILL
  } addrMode_e;

  typedef enum logic [1:0] { AS_FPTR, AS_ZPDATA, AS_ZPNEXT } addrSel_e;
  typedef enum logic [1:0] { IX_NONE, IX_X, IX_Y } idxSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadStart;
    logic     immStart;
    logic     fptrAdv;
    logic     setLo;
    logic     setHi;
    logic     latchZp;
    logic     memRd;
    addrSel_e addrSel;
    idxSel_e  idxSel;
    logic     idxZp;
    logic     ptrIdxX;
    logic     penaltyOk;
  } ctrlStrobe_t;

  function automatic addrMode_e decodeMode(input logic [OPC_W-1:0] opc, input logic wr);
    logic [2:0] grp;
    logic [2:0] fld;
    logic [1:0] cls;
    logic       useY;
    addrMode_e  m;
    grp  = opc[7:5];
    fld  = opc[4:2];
    cls  = opc[1:0];
    useY = (grp == 3'b100) || (grp == 3'b101);
    m    = MD_ILL;
    unique case (cls)
      2'b01: begin
        unique case (fld)
          3'b000: m = MD_INDX;
          3'b001: m = MD_ZP;
          3'b010: m = MD_IMM;
          3'b011: m = MD_ABS;
          3'b100: m = MD_INDY;
          3'b101: m = MD_ZPX;
          3'b110: m = MD_ABSY;
          default: m = MD_ABSX;
        endcase
      end
      2'b00: begin
        unique case (fld)
          3'b000: m = MD_IMM;
          3'b001: m = MD_ZP;
          3'b011: m = MD_ABS;
          3'b101: m = MD_ZPX;
          3'b111: m = MD_ABSX;
          default: m = MD_ILL;
        endcase
      end
      2'b10: begin
        unique case (fld)
          3'b000: m = MD_IMM;
          3'b001: m = MD_ZP;
          3'b010: m = MD_ACC;
          3'b011: m = MD_ABS;
          3'b101: m = useY ? MD_ZPY : MD_ZPX;
          3'b111: m = useY ? MD_ABSY : MD_ABSX;
          default: m = MD_ILL;
        endcase
      end
      default: m = MD_ILL;
    endcase
    if (m == MD_IMM && wr) m = MD_ILL;
    return m;
  endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic             isWrite,
  output ctrlStrobe_t      strb,
  output logic             done,
  output addrMode_e        modeR
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDLO, ST_GETLO, ST_GETHI, ST_GETPLO, ST_GETPHI, ST_DONE
  } state_e;

  state_e    state, nextState;
  logic      wrR;
  addrMode_e decoded;

  assign decoded = decodeMode(opcode, isWrite);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeR <= MD_NONE;
      wrR   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        modeR <= decoded;
        wrR   <= isWrite;
      end
    end
  end

  logic isAbs, isZp, isInd;
  assign isAbs = (modeR == MD_ABS) || (modeR == MD_ABSX) || (modeR == MD_ABSY);
  assign isZp  = (modeR == MD_ZP)  || (modeR == MD_ZPX)  || (modeR == MD_ZPY);
  assign isInd = (modeR == MD_INDX) || (modeR == MD_INDY);

  always_comb begin
    strb      = '0;
    nextState = state;
    // per-mode static controls
    unique case (modeR)
      MD_ZPX, MD_ABSX:          strb.idxSel = IX_X;
      MD_ZPY, MD_ABSY, MD_INDY: strb.idxSel = IX_Y;
      default:                  strb.idxSel = IX_NONE;
    endcase
    strb.idxZp     = (modeR == MD_ZPX) || (modeR == MD_ZPY);
    strb.ptrIdxX   = (modeR == MD_INDX);
    strb.penaltyOk = !wrR && ((modeR == MD_ABSX) || (modeR == MD_ABSY) || (modeR == MD_INDY));
    strb.addrSel   = AS_FPTR;

    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadStart = 1'b1;
          strb.immStart  = (decoded == MD_IMM);
          if (decoded == MD_IMM || decoded == MD_ACC || decoded == MD_ILL)
            nextState = ST_DONE;
          else
            nextState = ST_RDLO;
        end
      end
      ST_RDLO: begin
        strb.memRd   = 1'b1;
        strb.fptrAdv = 1'b1;
        nextState    = ST_GETLO;
      end
      ST_GETLO: begin
        strb.setLo = 1'b1;
        if (isAbs) begin
          strb.memRd   = 1'b1;
          strb.fptrAdv = 1'b1;
          nextState    = ST_GETHI;
        end else if (isInd) begin
          strb.memRd   = 1'b1;
          strb.addrSel = AS_ZPDATA;
          strb.latchZp = 1'b1;
          nextState    = ST_GETPLO;
        end else begin
          nextState = ST_DONE;
        end
      end
      ST_GETHI: begin
        strb.setHi = 1'b1;
        nextState  = ST_DONE;
      end
      ST_GETPLO: begin
        strb.setLo   = 1'b1;
        strb.memRd   = 1'b1;
        strb.addrSel = AS_ZPNEXT;
        nextState    = ST_GETPHI;
      end
      ST_GETPHI: begin
        strb.setHi = 1'b1;
        nextState  = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  logic unusedZp;
  assign unusedZp = isZp;

endmodule

// File: rtl/ea_dp.sv
module ea_dp
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              extraCycle,
  output logic [1:0]        bytesUsed
);

  logic [ADDR_W-1:0] fptr, base;
  logic [DATA_W-1:0] zpReg, xR, yR, zpNow, idx;
  logic [DATA_W:0]   lowSum;

  assign zpNow = memRdata + (strb.ptrIdxX ? xR : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fptr      <= '0;
      base      <= '0;
      zpReg     <= '0;
      xR        <= '0;
      yR        <= '0;
      bytesUsed <= '0;
    end else if (strb.loadStart) begin
      fptr      <= strb.immStart ? pcIn + 1'b1 : pcIn;
      base      <= strb.immStart ? pcIn : '0;
      bytesUsed <= strb.immStart ? 2'd1 : 2'd0;
      xR        <= xIdx;
      yR        <= yIdx;
    end else begin
      if (strb.fptrAdv) begin
        fptr      <= fptr + 1'b1;
        bytesUsed <= bytesUsed + 2'd1;
      end
      if (strb.setLo)   base[DATA_W-1:0]      <= memRdata;
      if (strb.setHi)   base[ADDR_W-1:DATA_W] <= memRdata;
      if (strb.latchZp) zpReg                 <= zpNow;
    end
  end

  always_comb begin
    unique case (strb.addrSel)
      AS_ZPDATA: memAddr = {{DATA_W{1'b0}}, zpNow};
      AS_ZPNEXT: memAddr = {{DATA_W{1'b0}}, zpReg + 1'b1};
      default:   memAddr = fptr;
    endcase
  end

  always_comb begin
    unique case (strb.idxSel)
      IX_X:    idx = xR;
      IX_Y:    idx = yR;
      default: idx = '0;
    endcase
  end

  assign lowSum     = {1'b0, base[DATA_W-1:0]} + {1'b0, idx};
  assign effAddr    = strb.idxZp ? {{DATA_W{1'b0}}, lowSum[DATA_W-1:0]}
                                 : base + {{DATA_W{1'b0}}, idx};
  assign extraCycle = strb.penaltyOk && lowSum[DATA_W];

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] xIdx,
  input  logic [DATA_W-1:0] yIdx,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              accTarget,
  output logic              immFlag,
  output logic              illegalFlag,
  output logic              extraCycle,
  output logic [1:0]        bytesUsed
);

  ctrlStrobe_t strb;
  addrMode_e   modeR;

  ea_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .isWrite(isWrite),
    .strb(strb), .done(done), .modeR(modeR)
  );

  ea_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .xIdx(xIdx), .yIdx(yIdx),
    .memRdata(memRdata), .memAddr(memAddr), .effAddr(effAddr),
    .extraCycle(extraCycle), .bytesUsed(bytesUsed)
  );

  assign memRd       = strb.memRd;
  assign accTarget   = (modeR == MD_ACC);
  assign immFlag     = (modeR == MD_IMM);
  assign illegalFlag = (modeR == MD_ILL);

endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memRd,
  input logic        done,
  input logic [15:0] effAddr,
  input logic        accTarget,
  input logic        immFlag,
  input logic        illegalFlag,
  input logic        extraCycle,
  input logic [1:0]  bytesUsed
);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_read_at_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRd);

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accTarget, immFlag, illegalFlag}));

  assert_acc_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && accTarget) |-> (bytesUsed == 2'd0 && effAddr == 16'h0000));

  assert_illegal_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegalFlag) |-> (bytesUsed == 2'd0 && effAddr == 16'h0000));

  assert_imm_one_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && immFlag) |-> (bytesUsed == 2'd1));

  assert_penalty_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    extraCycle |-> !(accTarget || immFlag || illegalFlag));

endmodule

bind ea_sequencer ea_sequencer_chk uChk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .done(done), .effAddr(effAddr),
  .accTarget(accTarget), .immFlag(immFlag), .illegalFlag(illegalFlag),
  .extraCycle(extraCycle), .bytesUsed(bytesUsed)
);

// File: tb/ea_sequencer_test.sv
module ea_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        isWrite = 1'b0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIdx = '0;
  logic [7:0]  yIdx = '0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memRdata = '0;
  logic        done;
  logic [15:0] effAddr;
  logic        accTarget, immFlag, illegalFlag, extraCycle;
  logic [1:0]  bytesUsed;

  int checks = 0;
  int fails = 0;
  int readCount = 0;

  always #5 clk = ~clk;

  ea_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .isWrite(isWrite),
    .pcIn(pcIn), .xIdx(xIdx), .yIdx(yIdx), .memAddr(memAddr), .memRd(memRd),
    .memRdata(memRdata), .done(done), .effAddr(effAddr), .accTarget(accTarget),
    .immFlag(immFlag), .illegalFlag(illegalFlag), .extraCycle(extraCycle),
    .bytesUsed(bytesUsed)
  );

  // memory model: content derived from address, answer one cycle later
  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (memRd) begin
      memRdata <= memByte(memAddr);
      readCount = readCount + 1;
    end
  end

  function automatic logic [7:0] mkOp(input logic [2:0] aaa, input logic [2:0] bbb,
                                      input logic [1:0] cc);
    return {aaa, bbb, cc};
  endfunction

  task automatic checkVal(input string tag, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic runCase(input string tag, input logic [7:0] opc, input logic wr,
                         input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                         input logic [15:0] expEff, input int expBytes, input logic expExtra,
                         input logic expAcc, input logic expImm, input logic expIll,
                         input int expLat, input int expReads);
    int lat;
    @(negedge clk);
    opcode = opc; isWrite = wr; pcIn = pc; xIdx = x; yIdx = y; start = 1'b1;
    readCount = 0;
    @(posedge clk);
    lat = 0;
    while (1) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done || lat > 20) break;
    end
    checkVal(tag, "latency", lat[15:0], expLat[15:0]);
    checkVal(tag, "effAddr", effAddr, expEff);
    checkVal(tag, "bytesUsed", {14'd0, bytesUsed}, expBytes[15:0]);
    checkVal(tag, "extraCycle", {15'd0, extraCycle}, {15'd0, expExtra});
    checkVal(tag, "flags acc/imm/ill", {13'd0, accTarget, immFlag, illegalFlag},
             {13'd0, expAcc, expImm, expIll});
    checkVal(tag, "read count", readCount[15:0], expReads[15:0]);
    @(negedge clk);
    checkVal(tag, "done pulse width", {15'd0, done}, 16'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkVal("R12", "reset outputs",
             {done, memRd, accTarget, immFlag, illegalFlag, extraCycle, bytesUsed, 8'd0},
             16'd0);
    checkVal("R12", "reset effAddr", effAddr, 16'd0);
  endtask

  // R1: class 01 table, read direction
  task automatic testClass01();
    logic [15:0] pc;
    logic [7:0]  lo, hi, pl, ph, z;
    pc = 16'h1234; lo = memByte(pc); hi = memByte(pc + 16'd1);
    runCase("R1 zp",  mkOp(3'b101, 3'b001, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {8'h00, lo}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
    runCase("R1 abs", mkOp(3'b101, 3'b011, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {hi, lo}, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R1 zpx", mkOp(3'b101, 3'b101, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {8'h00, lo + 8'h03}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
    runCase("R1 absy", mkOp(3'b101, 3'b110, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {hi, lo} + 16'h0005, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R1 absx", mkOp(3'b101, 3'b111, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {hi, lo} + 16'h0003, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    z = lo + 8'h03; pl = memByte({8'h00, z}); ph = memByte({8'h00, z + 8'h01});
    runCase("R1 indx", mkOp(3'b101, 3'b000, 2'b01), 1'b0, pc, 8'h03, 8'h05,
            {ph, pl}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 3);
  endtask

  // R2: class 00 and class 11
  task automatic testClass00();
    logic [15:0] pc;
    logic [7:0]  lo, hi;
    pc = 16'h4000; lo = memByte(pc); hi = memByte(pc + 16'd1);
    runCase("R2 absx", mkOp(3'b001, 3'b111, 2'b00), 1'b0, pc, 8'h10, 8'h00,
            {hi, lo} + 16'h0010, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R2 ill010", mkOp(3'b001, 3'b010, 2'b00), 1'b0, pc, 8'h10, 8'h00,
            16'h0000, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    runCase("R2 ill110", mkOp(3'b001, 3'b110, 2'b00), 1'b0, pc, 8'h10, 8'h00,
            16'h0000, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    runCase("R2 class11", mkOp(3'b000, 3'b001, 2'b11), 1'b0, pc, 8'h10, 8'h00,
            16'h0000, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
  endtask

  // R3: class 10 accumulator, illegal, Y substitution
  task automatic testClass10();
    logic [15:0] pc;
    logic [7:0]  lo, hi;
    pc = 16'h2345; lo = memByte(pc); hi = memByte(pc + 16'd1);
    runCase("R3 acc", mkOp(3'b000, 3'b010, 2'b10), 1'b0, pc, 8'h21, 8'h42,
            16'h0000, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0);
    runCase("R3 ill100", mkOp(3'b000, 3'b100, 2'b10), 1'b0, pc, 8'h21, 8'h42,
            16'h0000, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    runCase("R3 zpy sub", mkOp(3'b101, 3'b101, 2'b10), 1'b0, pc, 8'h21, 8'h42,
            {8'h00, lo + 8'h42}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
    runCase("R3 zpx other", mkOp(3'b110, 3'b101, 2'b10), 1'b1, pc, 8'h21, 8'h42,
            {8'h00, lo + 8'h21}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
    runCase("R3 absy sub", mkOp(3'b100, 3'b111, 2'b10), 1'b1, pc, 8'h21, 8'h42,
            {hi, lo} + 16'h0042, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
  endtask

  // R4: zero-page index wraps in page zero
  task automatic testZpWrap();
    logic [15:0] pc;
    logic [7:0]  lo;
    pc = 16'h0200; lo = memByte(pc);
    runCase("R4 zpx wrap", mkOp(3'b101, 3'b101, 2'b01), 1'b0, pc, 8'hF0, 8'h00,
            {8'h00, lo + 8'hF0}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
  endtask

  // R5 / R9: absolute index crossing a page
  task automatic testAbsCross();
    logic [15:0] pc;
    logic [7:0]  lo, hi;
    pc = 16'h3456; lo = memByte(pc); hi = memByte(pc + 16'd1);
    runCase("R5 R9 absy cross read", mkOp(3'b101, 3'b110, 2'b01), 1'b0, pc, 8'h00, 8'hFF,
            {hi, lo} + 16'h00FF, 2, (lo != 8'h00), 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R9 absx cross write", mkOp(3'b100, 3'b111, 2'b01), 1'b1, pc, 8'hFF, 8'h00,
            {hi, lo} + 16'h00FF, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R9 absx no cross", mkOp(3'b101, 3'b111, 2'b01), 1'b0, pc, 8'h00, 8'h00,
            {hi, lo}, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
    runCase("R9 zpx never", mkOp(3'b101, 3'b101, 2'b01), 1'b0, pc, 8'hFF, 8'h00,
            {8'h00, lo + 8'hFF}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
  endtask

  // R6: pointer straddling 0xFF wraps to 0x00
  task automatic testIndxWrap();
    logic [15:0] pc;
    logic [7:0]  lo, pl, ph;
    pc = 16'h0300; lo = memByte(pc);
    pl = memByte(16'h00FF); ph = memByte(16'h0000);
    runCase("R6 indx wrap", mkOp(3'b101, 3'b000, 2'b01), 1'b0, pc, 8'hFF - lo, 8'h00,
            {ph, pl}, 1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 3);
  endtask

  // R7: post-indexed, with and without page cross
  task automatic testIndy();
    logic [15:0] pc, ptr;
    logic [7:0]  lo;
    logic [8:0]  s;
    pc = 16'h0510; lo = memByte(pc);
    ptr = {memByte({8'h00, lo + 8'h01}), memByte({8'h00, lo})};
    s = {1'b0, ptr[7:0]} + 9'h0FF;
    runCase("R7 R9 indy read", mkOp(3'b101, 3'b100, 2'b01), 1'b0, pc, 8'h00, 8'hFF,
            ptr + 16'h00FF, 1, s[8], 1'b0, 1'b0, 1'b0, 5, 3);
    runCase("R7 R9 indy write", mkOp(3'b100, 3'b100, 2'b01), 1'b1, pc, 8'h00, 8'hFF,
            ptr + 16'h00FF, 1, 1'b0, 1'b0, 1'b0, 1'b0, 5, 3);
  endtask

  // R8 / R10: immediate and consecutive operand fetch
  task automatic testImm();
    runCase("R8 imm read", mkOp(3'b101, 3'b010, 2'b01), 1'b0, 16'hBEEF, 8'h00, 8'h00,
            16'hBEEF, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1, 0);
    runCase("R8 imm write", mkOp(3'b100, 3'b010, 2'b01), 1'b1, 16'hBEEF, 8'h00, 8'h00,
            16'h0000, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    runCase("R10 abs at page end", mkOp(3'b001, 3'b011, 2'b00), 1'b0, 16'h12FF, 8'h00, 8'h00,
            {memByte(16'h1300), memByte(16'h12FF)}, 2, 1'b0, 1'b0, 1'b0, 1'b0, 4, 2);
  endtask

  // R11: start while busy is ignored
  task automatic testBusyStart();
    logic [15:0] pc;
    int lat;
    pc = 16'h0700;
    @(negedge clk);
    opcode = mkOp(3'b101, 3'b011, 2'b01); isWrite = 1'b0; pcIn = pc; start = 1'b1;
    @(posedge clk);
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      opcode = mkOp(3'b000, 3'b010, 2'b10); pcIn = 16'h0000;
      if (done || lat > 20) break;
    end
    start = 1'b0;
    checkVal("R11 busy", "latency", lat[15:0], 16'd4);
    checkVal("R11 busy", "effAddr", effAddr, {memByte(pc + 16'd1), memByte(pc)});
    checkVal("R11 busy", "accTarget", {15'd0, accTarget}, 16'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testClass01();
    testClass00();
    testClass10();
    testZpWrap();
    testAbsCross();
    testIndxWrap();
    testIndy();
    testImm();
    testBusyStart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule